// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor bus three 8-bit general-purpose parallel ports, named A, B and C. Port C is handled as two 4-bit halves. The processor talks to the block through an 8-bit data bus with a chip select, read and write strobes and a 2-bit register address. Every access is sampled on the rising edge of the block clock. Each pad appears as a separate input, output and output-enable signal, so the pad ring builds the tri-state buffers.

Software programs the block by writing to one control address. When data bit 7 is set, the byte is a configuration word. It chooses input or output for each of the four port sections and stores the operating-mode code of each control group. When data bit 7 is clear, the byte is a command that forces one selected port C output bit high or low and leaves the other seven bits as they were. Only the unstrobed basic behaviour is implemented. The strobed mode codes are stored and read back, but they do not change how the ports behave.

Top module: `par_port_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the control register reads back 0x9B, every output latch is zero, every port output enable is low, and dout_oe is low.
- R2: A write at address 3 with din[7]=1 stores din[6:0] as the configuration. A read at address 3 returns the stored bits with bit 7 forced to 1. Mode codes in bits 6:5 and bit 2 are stored and returned unchanged for any value.
- R3: Direction bits take effect on the clock edge of the configuration write, with 1 meaning input. Bit 4 selects port A, bit 1 selects port B, bit 3 selects port C bits 7:4 and bit 0 selects port C bits 3:0. Every output-enable bit of a section is high exactly when that section is an output.
- R4: A configuration write clears the port A, B and C output latches to zero.
- R5: Writes at address 0, 1 and 2 load the port A, B and C output latches. Each latch drives its pa_out, pb_out or pc_out pins.
- R6: A write at address 3 with din[7]=0 changes only port C latch bit din[3:1], setting it to din[0]. Bits 6:4 are ignored, the configuration is unchanged, and the command works under any stored mode codes.
- R7: A read at address 0, 1 or 2 returns the output latch for a section configured as output and the live input pins for a section configured as input. Each half of port C is chosen on its own.
- R8: dout_oe is high only while cs_n and rd_n are both low. When dout_oe is low, dout is zero.
- R9: While cs_n is high, wr_n has no effect on any latch or on the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; one write per cycle held low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor |
| dout_oe | output | 1 | Enable for the processor data bus driver |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pad output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pad output enables |

## Verification
If the configuration register holds a wrong value, the fault shows at the ports in two ways. The output-enable signals change on the next clock edge, and a read of the control address gives a different value in the same cycle as the read. If a latch holds a wrong value, it appears on the pad outputs right away. It also appears on dout for any read of that port while the section is an output. A bit command that hits the wrong bit, or changes more than one bit, shows on pc_out one edge after the command. So the bench compares pad outputs and read data right after each write, with no settling interval.

// File: rtl/ppc_pkg.sv
// Package: shared types for the parallel port controller.
// Assumes 8-bit ports and a 7-bit stored configuration word.
package ppc_pkg;

    // Stored configuration, bit order matches the written data bits 6..0
    typedef struct packed {
        logic [1:0] a_mode;   // group A operating-mode code
        logic       a_in;     // port A is input
        logic       cu_in;    // port C upper half is input
        logic       b_mode;   // group B operating-mode code
        logic       b_in;     // port B is input
        logic       cl_in;    // port C lower half is input
    } cfg_t;

    localparam cfg_t CFG_RESET = 7'h1B;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ppc_ctrl.sv
// Module: ppc_ctrl
// Decodes processor writes into configuration loads, port C bit commands
// and per-port latch loads, and holds the configuration register.
// Assumes a write lasts one clock with cs_n and wr_n low.
module ppc_ctrl
    import ppc_pkg::*;
#(
    parameter int W     = 8,
    parameter int NPORT = 3,
    localparam int SELW = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic [1:0]       addr,
    input  logic [W-1:0]     din,
    output cfg_t             cfg,
    output logic             cfg_wr,
    output logic             bit_wr,
    output logic [SELW-1:0]  bit_sel,
    output logic             bit_val,
    output logic [NPORT-1:0] port_wr
);

    logic wr_act;
    logic ctl_hit;

    // Qualify the write strobe and find control-address accesses
    always_comb begin
        wr_act  = !cs_n && !wr_n;
        ctl_hit = wr_act && (addr == SEL_CTRL);
        cfg_wr  = ctl_hit && din[W-1];
        bit_wr  = ctl_hit && !din[W-1];
        bit_sel = din[SELW:1];
        bit_val = din[0];
    end

    // One load strobe per port latch address
    for (genvar p = 0; p < NPORT; p++) begin : g_port_dec
        assign port_wr[p] = wr_act && (addr == 2'(p));
    end

    // Configuration register: reset value, or load on a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RESET;
        else if (cfg_wr)
            cfg <= cfg_t'(din[W-2:0]);
    end

    a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg == cfg_t'($past(din[W-2:0])));
    a_r6_bit_cmd_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        bit_wr |=> $stable(cfg));
    a_r9_deselect_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(cfg));

endmodule

// File: rtl/ppc_out_latch.sv
// Module: ppc_out_latch
// One port output latch: cleared by a configuration write, loaded whole by a
// port write, or changed one bit at a time by a bit command.
// Assumes clr, ld and bit_en are never active together; clr wins, then ld.
module ppc_out_latch #(
    parameter int W = 8,
    localparam int SELW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            ld,
    input  logic [W-1:0]    ld_data,
    input  logic            bit_en,
    input  logic [SELW-1:0] bit_sel,
    input  logic            bit_val,
    output logic [W-1:0]    q
);

    logic [W-1:0] bit_next;

    // Per-bit next value for the single-bit command
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_next[i] = (bit_sel == SELW'(i)) ? bit_val : q[i];
    end

    // Latch update with priority clear > load > bit command
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            q <= '0;
        else if (ld)
            q <= ld_data;
        else if (bit_en)
            q <= bit_next;
    end

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
    a_r6_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !ld) |=> $countones(q ^ $past(q)) <= 1);
    a_r6_bit_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !ld) |=> q[$past(bit_sel)] == $past(bit_val));

endmodule

// File: rtl/ppc_read_mux.sv
// Module: ppc_read_mux
// Builds processor read data: the latch for output sections, the pins for
// input sections, or the configuration with bit 7 forced high.
// Assumes reads are combinational and have no side effects.
module ppc_read_mux
    import ppc_pkg::*;
#(
    parameter int W = 8,
    localparam int HALF = W / 2
) (
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic [1:0]   addr,
    input  cfg_t         cfg,
    input  logic [W-1:0] a_lat,
    input  logic [W-1:0] b_lat,
    input  logic [W-1:0] c_lat,
    input  logic [W-1:0] a_pin,
    input  logic [W-1:0] b_pin,
    input  logic [W-1:0] c_pin,
    output logic [W-1:0] rdata,
    output logic         rd_oe
);

    logic [W-1:0] c_view;
    logic [W-1:0] sel;

    // Port C view with each half chosen by its own direction bit
    always_comb begin
        c_view[W-1:HALF] = cfg.cu_in ? c_pin[W-1:HALF] : c_lat[W-1:HALF];
        c_view[HALF-1:0] = cfg.cl_in ? c_pin[HALF-1:0] : c_lat[HALF-1:0];
    end

    // Address select and bus qualification
    always_comb begin
        rd_oe = !cs_n && !rd_n;
        unique case (addr)
            SEL_A:    sel = cfg.a_in ? a_pin : a_lat;
            SEL_B:    sel = cfg.b_in ? b_pin : b_lat;
            SEL_C:    sel = c_view;
            default:  sel = {1'b1, cfg};
        endcase
        rdata = rd_oe ? sel : '0;
    end

endmodule

// File: rtl/par_port_ctrl.sv
// Module: par_port_ctrl (top)
// Three-port parallel I/O controller with a processor bus side. Connects the
// write decoder, three output latches and the read multiplexer, and derives
// the pad output enables from the direction bits.
// Assumes synchronous bus sampling on clk and external tri-state pads.
module par_port_ctrl
    import ppc_pkg::*;
#(
    parameter int W = 8,
    localparam int HALF  = W / 2,
    localparam int NPORT = 3,
    localparam int SELW  = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_oe,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);

    cfg_t             cfg;
    logic             cfg_wr;
    logic             bit_wr;
    logic [SELW-1:0]  bit_sel;
    logic             bit_val;
    logic [NPORT-1:0] port_wr;

    ppc_ctrl #(.W(W), .NPORT(NPORT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .cfg     (cfg),
        .cfg_wr  (cfg_wr),
        .bit_wr  (bit_wr),
        .bit_sel (bit_sel),
        .bit_val (bit_val),
        .port_wr (port_wr)
    );

    ppc_out_latch #(.W(W)) u_lat_a (
        .clk (clk), .rst_n (rst_n), .clr (cfg_wr),
        .ld (port_wr[SEL_A]), .ld_data (din),
        .bit_en (1'b0), .bit_sel (bit_sel), .bit_val (bit_val),
        .q (pa_out)
    );

    ppc_out_latch #(.W(W)) u_lat_b (
        .clk (clk), .rst_n (rst_n), .clr (cfg_wr),
        .ld (port_wr[SEL_B]), .ld_data (din),
        .bit_en (1'b0), .bit_sel (bit_sel), .bit_val (bit_val),
        .q (pb_out)
    );

    ppc_out_latch #(.W(W)) u_lat_c (
        .clk (clk), .rst_n (rst_n), .clr (cfg_wr),
        .ld (port_wr[SEL_C]), .ld_data (din),
        .bit_en (bit_wr), .bit_sel (bit_sel), .bit_val (bit_val),
        .q (pc_out)
    );

    ppc_read_mux #(.W(W)) u_rd (
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .addr  (addr),
        .cfg   (cfg),
        .a_lat (pa_out),
        .b_lat (pb_out),
        .c_lat (pc_out),
        .a_pin (pa_in),
        .b_pin (pb_in),
        .c_pin (pc_in),
        .rdata (dout),
        .rd_oe (dout_oe)
    );

    // Pad output enables follow the direction bits section by section
    always_comb begin
        pa_oe = {W{!cfg.a_in}};
        pb_oe = {W{!cfg.b_in}};
        pc_oe = {{HALF{!cfg.cu_in}}, {HALF{!cfg.cl_in}}};
    end

    a_r3_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1));
    a_r3_oe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> pa_oe[0] == !$past(din[4]) && pb_oe[0] == !$past(din[1]));
    a_r8_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dout_oe && dout == '0));
    a_r9_deselect_holds_latches: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out));

endmodule

// File: tb/tb_par_port_ctrl.sv
`timescale 1ns/1ps
module tb_par_port_ctrl;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       cs_n = 1, rd_n = 1, wr_n = 1;
    logic [1:0] addr = 0;
    logic [7:0] din = 0;
    logic [7:0] dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic       dout_oe;
    logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #2.5 clk = ~clk;

    par_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // Fields: cfg, wa, wb, wc, pin a, pin b, pin c, exp a, exp b, exp c, exp oe {A,CU,B,CL}
    localparam logic [83:0] VEC [0:4] = '{
        {8'h80, 8'h11, 8'h22, 8'h33, 8'hA5, 8'hB6, 8'hC7, 8'h11, 8'h22, 8'h33, 4'b1111},
        {8'h9B, 8'h11, 8'h22, 8'h33, 8'hA5, 8'hB6, 8'hC7, 8'hA5, 8'hB6, 8'hC7, 4'b0000},
        {8'h88, 8'h5A, 8'hC3, 8'h3C, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hC3, 8'hAC, 4'b1011},
        {8'h92, 8'h77, 8'h88, 8'h96, 8'h12, 8'h34, 8'h0F, 8'h12, 8'h34, 8'h96, 4'b0101},
        {8'hE5, 8'h01, 8'h02, 8'hF0, 8'h00, 8'h00, 8'h5A, 8'h01, 8'h02, 8'hFA, 4'b1110}
    };

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 0; rd_n = 0; addr = a;
        #1;
        d = dout;
        check(dout_oe === 1'b1, "R8 dout_oe during read", {7'd0, dout_oe}, 8'h01);
        cs_n = 1; rd_n = 1;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state
        #1;
        check(pa_oe == 0 && pb_oe == 0 && pc_oe == 0, "R1 oe after reset", pa_oe | pb_oe | pc_oe, 8'h00);
        check(pa_out == 0 && pb_out == 0 && pc_out == 0, "R1 latches after reset", pa_out | pb_out | pc_out, 8'h00);
        check(dout_oe == 0 && dout == 0, "R1 bus idle after reset", dout, 8'h00);
        bus_read(2'd3, r);
        check(r == 8'h9B, "R1 control readback after reset", r, 8'h9B);

        // Vector table: R2 R3 R5 R7
        for (int v = 0; v < 5; v++) begin
            logic [83:0] e;
            logic [3:0]  oe;
            e = VEC[v];
            bus_write(2'd3, e[83:76]);
            bus_write(2'd0, e[75:68]);
            bus_write(2'd1, e[67:60]);
            bus_write(2'd2, e[59:52]);
            pa_in = e[51:44]; pb_in = e[43:36]; pc_in = e[35:28];
            bus_read(2'd0, r);
            check(r == e[27:20], "R7 port A read", r, e[27:20]);
            bus_read(2'd1, r);
            check(r == e[19:12], "R7 port B read", r, e[19:12]);
            bus_read(2'd2, r);
            check(r == e[11:4], "R7 port C read", r, e[11:4]);
            oe = {pa_oe[0], pc_oe[4], pb_oe[0], pc_oe[0]};
            check(oe == e[3:0] && (pa_oe == 0 || pa_oe == 8'hFF) && (pc_oe[7:4] == {4{oe[2]}})
                  && (pc_oe[3:0] == {4{oe[0]}}), "R3 output enables", {4'd0, oe}, {4'd0, e[3:0]});
            check(pa_out == e[75:68], "R5 pa_out", pa_out, e[75:68]);
            check(pb_out == e[67:60], "R5 pb_out", pb_out, e[67:60]);
            check(pc_out == e[59:52], "R5 pc_out", pc_out, e[59:52]);
            bus_read(2'd3, r);
            check(r == (e[83:76] | 8'h80), "R2 control readback", r, e[83:76] | 8'h80);
        end

        // R4: configuration write clears latches
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hEE);
        bus_write(2'd2, 8'hDD);
        bus_write(2'd3, 8'h80);
        check(pa_out == 0 && pb_out == 0 && pc_out == 0, "R4 latches cleared", pa_out | pb_out | pc_out, 8'h00);
        bus_read(2'd0, r);
        check(r == 8'h00, "R4 port A reads zero", r, 8'h00);

        // R6: single-bit commands on port C
        bus_write(2'd3, 8'h7B);
        check(pc_out == 8'h20, "R6 set bit 5, bits 6:4 ignored", pc_out, 8'h20);
        bus_write(2'd3, 8'h01);
        check(pc_out == 8'h21, "R6 set bit 0", pc_out, 8'h21);
        bus_write(2'd3, 8'h0F);
        check(pc_out == 8'hA1, "R6 set bit 7", pc_out, 8'hA1);
        bus_write(2'd3, 8'h0A);
        check(pc_out == 8'h81, "R6 clear bit 5", pc_out, 8'h81);
        check(pa_out == 0 && pb_out == 0, "R6 other ports untouched", pa_out | pb_out, 8'h00);
        bus_read(2'd3, r);
        check(r == 8'h80, "R6 configuration unchanged", r, 8'h80);
        bus_write(2'd3, 8'hE4);
        bus_write(2'd3, 8'h07);
        check(pc_out == 8'h08, "R6 bit command under strobed mode codes", pc_out, 8'h08);

        // R9: writes while deselected
        bus_write(2'd0, 8'h3C);
        @(negedge clk);
        cs_n = 1; wr_n = 0; addr = 2'd0; din = 8'hC3;
        @(negedge clk);
        addr = 2'd3; din = 8'h9B;
        @(negedge clk);
        addr = 2'd2; din = 8'hFF;
        @(negedge clk);
        wr_n = 1;
        check(pa_out == 8'h3C, "R9 port A latch held", pa_out, 8'h3C);
        check(pc_out == 8'h08, "R9 port C latch held", pc_out, 8'h08);
        bus_read(2'd3, r);
        check(r == 8'hE4, "R9 configuration held", r, 8'hE4);

        // R8: read strobe without chip select
        @(negedge clk);
        cs_n = 1; rd_n = 0; addr = 2'd3;
        #1;
        check(dout_oe == 0 && dout == 0, "R8 no drive when deselected", dout, 8'h00);
        cs_n = 0; rd_n = 1;
        #1;
        check(dout_oe == 0 && dout == 0, "R8 no drive without read strobe", dout, 8'h00);
        cs_n = 1;

        // R1: reset after activity
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        #1;
        check(pc_out == 0 && pa_out == 0 && pc_oe == 0, "R1 reset clears state", pc_out | pa_out, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule